// File: doc/BRIEF.md
# Hybrid Jump Counter Sequencer

This block is the control unit of a small accumulator processor with four instructions: load, store, add and branch-if-negative. A 4-bit state counter holds the control state. On most cycles the counter either counts up to the next state, clears back to the fetch state, or holds while memory is busy. Only the decode state is different. There the counter loads a start state that a small lookup returns for the two opcode bits. The states are numbered so that each instruction's common path runs in ascending order.

The state value is decoded into one line per state. Those lines, together with the synchronized memory wait input and reset, produce three counter controls: clear, load and count. The same lines produce the datapath strobes and the memory request, read and write signals. The datapath and the memory sit outside the block. The current state is also brought out as a port so that the surrounding logic and the testbench can observe it.

Top module: `jc_sequencer`

## Requirements
- R1: While `rst` is 1, the state on the next clock edge is 0 whatever the other inputs are, and `pc_clear` is 1 in the same cycle.
- R2: In state 4, the next state comes from the opcode bits: 2'b00 gives 5, 2'b01 gives 8, 2'b10 gives 10 and 2'b11 gives 13.
- R3: States 7, 12 and 13 always return to state 0 on the next edge. State 9 returns to 0 when `mem_wait` is 0.
- R4: States 0, 5, 8 and 10 always advance by one. States 1 and 3 advance by one only when `mem_wait` is 1. States 2, 6 and 11 advance by one only when `mem_wait` is 0.
- R5: When no clear, load or count applies (for example state 1 with `mem_wait` 0, or state 2 with `mem_wait` 1), the state stays the same.
- R6: Clear takes priority over load, and load takes priority over count. State 9 with `mem_wait` 0 goes to 0, not 10. A reset in state 4 gives 0, not the jump target.
- R7: `mem_req` is 1 exactly when the state is one of 1, 2, 5, 6, 8, 9, 11 or 12 and `mem_wait` is 0. While `mem_req` is 1, `mem_wr` is 1 in states 8 and 9 and `mem_rd` is 1 in the other states. Both are 0 whenever `mem_req` is 0.
- R8: `pc_inc_mar` is 1 only in state 0. `ir_load` is 1 only in state 3 with `mem_wait` 1. `ac_from_mbr` is 1 only in state 7. `ac_add` is 1 only in state 12.
- R9: In state 4, `mar_from_ir` is 1 for every opcode except 2'b11, and `mbr_from_ac` is 1 only for opcode 2'b01.
- R10: `pc_from_ir` is 1 only in state 13 when `ac_sign` is 1.
- R11: Each opcode visits its states in this order before it returns to 0. Load: 0,1,2,3,4,5,6,7. Store: 0,1,2,3,4,8,9. Add: 0,1,2,3,4,10,11,12. Branch: 0,1,2,3,4,13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, acts as a counter clear |
| mem_wait | input | 1 | Synchronized memory wait |
| opcode | input | 2 | Opcode bits from the instruction register |
| ac_sign | input | 1 | Accumulator sign bit |
| state | output | 4 | Current counter value |
| pc_clear | output | 1 | Clear the program counter |
| pc_inc_mar | output | 1 | Copy PC to MAR and increment PC |
| ir_load | output | 1 | Copy MBR to IR |
| mar_from_ir | output | 1 | Copy the IR address field to MAR |
| mbr_from_ac | output | 1 | Copy AC to MBR |
| ac_from_mbr | output | 1 | Copy MBR to AC |
| ac_add | output | 1 | Write AC plus MBR into AC |
| pc_from_ir | output | 1 | Copy the IR address field to PC |
| mem_req | output | 1 | Memory request |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |

## Verification
The assertions assume that `mem_wait` is already synchronous to `clk`. They also assume that the opcode and sign inputs are steady at each edge, because they come from registers. The bench changes every input only on the falling edge, so these assumptions hold. It keeps the opcode fixed for a whole instruction, which gives a path that can be compared against a fixed list. `mem_wait` follows a pseudo-random bit stream, so the states that stall see long and short waits in both polarities.

// File: rtl/jc_pkg.sv
package jc_pkg;
    localparam int STATE_W = 4;
    localparam int OP_W    = 2;

    typedef logic [STATE_W-1:0] state_t;

    // Start state for each instruction; the dispatch depends on this order
    function automatic state_t jump_target(input logic [OP_W-1:0] op);
        case (op)
            2'b00:   jump_target = state_t'(5);
            2'b01:   jump_target = state_t'(8);
            2'b10:   jump_target = state_t'(10);
            default: jump_target = state_t'(13);
        endcase
    endfunction

    typedef struct packed {
        logic clr;
        logic ld;
        logic cnt;
    } cnt_ctl_t;

    typedef struct packed {
        state_t st;
    } cnt_reg_t;
endpackage

// File: rtl/jc_jump_rom.sv
module jc_jump_rom
    import jc_pkg::*;
#(
    parameter int ENTRIES = 2**OP_W
) (
    input  logic [OP_W-1:0] op,
    output state_t          target
);
    state_t table_w [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign table_w[i] = jump_target(OP_W'(i));
    end

    assign target = table_w[op];
endmodule

// File: rtl/jc_decode.sv
module jc_decode
    import jc_pkg::*;
#(
    parameter int NSTATES = 2**STATE_W
) (
    input  state_t          st,
    input  logic            rst,
    input  logic            mem_wait,
    input  logic [OP_W-1:0] op,
    input  logic            ac_sign,
    output cnt_ctl_t        ctl,
    output logic            pc_clear,
    output logic            pc_inc_mar,
    output logic            ir_load,
    output logic            mar_from_ir,
    output logic            mbr_from_ac,
    output logic            ac_from_mbr,
    output logic            ac_add,
    output logic            pc_from_ir,
    output logic            mem_req,
    output logic            mem_rd,
    output logic            mem_wr
);
    logic [NSTATES-1:0] s;

    for (genvar i = 0; i < NSTATES; i++) begin : g_line
        assign s[i] = (st == state_t'(i));
    end

    logic mem_state, wr_state, unused_code;

    always_comb begin
        mem_state   = s[1] | s[2] | s[5] | s[6] | s[8] | s[9] | s[11] | s[12];
        wr_state    = s[8] | s[9];
        unused_code = s[14] | s[15];

        ctl.clr = rst | s[7] | s[12] | s[13] | (s[9] & ~mem_wait) | unused_code;
        ctl.ld  = s[4];
        ctl.cnt = s[0] | s[5] | s[8] | s[10]
                | (mem_wait & (s[1] | s[3]))
                | (~mem_wait & (s[2] | s[6] | s[9] | s[11]));

        pc_clear    = rst;
        pc_inc_mar  = s[0];
        ir_load     = s[3] & mem_wait;
        mar_from_ir = s[4] & (op != 2'b11);
        mbr_from_ac = s[4] & (op == 2'b01);
        ac_from_mbr = s[7];
        ac_add      = s[12];
        pc_from_ir  = s[13] & ac_sign;
        mem_req     = mem_state & ~mem_wait;
        mem_wr      = mem_req & wr_state;
        mem_rd      = mem_req & ~wr_state;
    end

    always_comb begin
        assert (!(mem_rd && mem_wr)) else $error("assert_rd_wr_excl_R7");
    end
endmodule

// File: rtl/jc_counter.sv
module jc_counter
    import jc_pkg::*;
(
    input  logic     clk,
    input  cnt_ctl_t ctl,
    input  state_t   target,
    output state_t   st
);
    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl.clr)      r_d.st = '0;
        else if (ctl.ld)  r_d.st = target;
        else if (ctl.cnt) r_d.st = r_q.st + 1'b1;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign st = r_q.st;

    assert property (@(posedge clk) ctl.clr |=> (st == '0))
        else $error("assert_clear_wins_R6");
    assert property (@(posedge clk) (!ctl.clr && !ctl.ld && !ctl.cnt) |=> $stable(st))
        else $error("assert_hold_idle_R5");
endmodule

// File: rtl/jc_sequencer.sv
module jc_sequencer
    import jc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mem_wait,
    input  logic [OP_W-1:0]     opcode,
    input  logic                ac_sign,
    output logic [STATE_W-1:0]  state,
    output logic                pc_clear,
    output logic                pc_inc_mar,
    output logic                ir_load,
    output logic                mar_from_ir,
    output logic                mbr_from_ac,
    output logic                ac_from_mbr,
    output logic                ac_add,
    output logic                pc_from_ir,
    output logic                mem_req,
    output logic                mem_rd,
    output logic                mem_wr
);
    state_t   st, target;
    cnt_ctl_t ctl;

    jc_jump_rom u_rom (.op(opcode), .target(target));

    jc_decode u_dec (
        .st(st), .rst(rst), .mem_wait(mem_wait), .op(opcode), .ac_sign(ac_sign),
        .ctl(ctl), .pc_clear(pc_clear), .pc_inc_mar(pc_inc_mar), .ir_load(ir_load),
        .mar_from_ir(mar_from_ir), .mbr_from_ac(mbr_from_ac), .ac_from_mbr(ac_from_mbr),
        .ac_add(ac_add), .pc_from_ir(pc_from_ir), .mem_req(mem_req),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    jc_counter u_cnt (.clk(clk), .ctl(ctl), .target(target), .st(st));

    assign state = st;

    assert property (@(posedge clk) rst |=> (state == '0))
        else $error("assert_reset_zero_R1");
    assert property (@(posedge clk) disable iff (rst)
        (state == 4'd4 && opcode == 2'b01) |=> (state == 4'd8))
        else $error("assert_store_dispatch_R2");
    assert property (@(posedge clk) disable iff (rst)
        (state == 4'd7 || state == 4'd12 || state == 4'd13) |=> (state == '0))
        else $error("assert_end_clear_R3");
    assert property (@(posedge clk) disable iff (rst)
        (state == 4'd1 && mem_wait) |=> (state == 4'd2))
        else $error("assert_count_wait_R4");
    assert property (@(posedge clk) disable iff (rst)
        (state == 4'd2 && mem_wait) |=> $stable(state))
        else $error("assert_stall_R5");
    assert property (@(posedge clk) disable iff (rst)
        (state == 4'd9 && !mem_wait) |=> (state == '0))
        else $error("assert_store_done_R6");
    assert property (@(posedge clk) disable iff (rst)
        pc_from_ir |-> (state == 4'd13 && ac_sign))
        else $error("assert_branch_take_R10");
endmodule

// File: tb/jc_sequencer_bench.sv
module jc_sequencer_bench;
    logic clk = 1'b0;
    logic rst, mem_wait, ac_sign;
    logic [1:0] opcode;
    logic [3:0] state;
    logic pc_clear, pc_inc_mar, ir_load, mar_from_ir, mbr_from_ac, ac_from_mbr;
    logic ac_add, pc_from_ir, mem_req, mem_rd, mem_wr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    jc_sequencer u_jc_sequencer (
        .clk(clk), .rst(rst), .mem_wait(mem_wait), .opcode(opcode), .ac_sign(ac_sign),
        .state(state), .pc_clear(pc_clear), .pc_inc_mar(pc_inc_mar), .ir_load(ir_load),
        .mar_from_ir(mar_from_ir), .mbr_from_ac(mbr_from_ac), .ac_from_mbr(ac_from_mbr),
        .ac_add(ac_add), .pc_from_ir(pc_from_ir), .mem_req(mem_req),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] tgt(input logic [1:0] op);
        case (op)
            2'b00: return 4'd5;
            2'b01: return 4'd8;
            2'b10: return 4'd10;
            default: return 4'd13;
        endcase
    endfunction

    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic w,
                                            input logic [1:0] op, input logic r);
        if (r) return 4'd0;
        if (s == 7 || s == 12 || s == 13 || s > 13) return 4'd0;
        if (s == 9 && !w) return 4'd0;
        if (s == 4) return tgt(op);
        if (s == 0 || s == 5 || s == 8 || s == 10) return s + 4'd1;
        if ((s == 1 || s == 3) && w) return s + 4'd1;
        if ((s == 2 || s == 6 || s == 11) && !w) return s + 4'd1;
        return s;
    endfunction

    // Drive inputs at negedge, check combinational outputs, check state at next negedge
    task automatic step(input logic w, input logic r);
        logic [3:0] s, nx;
        bit memst, req;
        mem_wait = w;
        rst = r;
        #2;
        s = state;
        memst = (s == 1 || s == 2 || s == 5 || s == 6 || s == 8 || s == 9 || s == 11 || s == 12);
        req = memst && !w;
        check(pc_clear == r, "R1 pc_clear", pc_clear, r);
        check(mem_req == req, "R7 mem_req", mem_req, req);
        check(mem_wr == (req && (s == 8 || s == 9)), "R7 mem_wr", mem_wr, req && (s == 8 || s == 9));
        check(mem_rd == (req && !(s == 8 || s == 9)), "R7 mem_rd", mem_rd, req && !(s == 8 || s == 9));
        check(pc_inc_mar == (s == 0), "R8 pc_inc_mar", pc_inc_mar, s == 0);
        check(ir_load == (s == 3 && w), "R8 ir_load", ir_load, s == 3 && w);
        check(ac_from_mbr == (s == 7), "R8 ac_from_mbr", ac_from_mbr, s == 7);
        check(ac_add == (s == 12), "R8 ac_add", ac_add, s == 12);
        check(mar_from_ir == (s == 4 && opcode != 2'b11), "R9 mar_from_ir", mar_from_ir, s == 4 && opcode != 2'b11);
        check(mbr_from_ac == (s == 4 && opcode == 2'b01), "R9 mbr_from_ac", mbr_from_ac, s == 4 && opcode == 2'b01);
        check(pc_from_ir == (s == 13 && ac_sign), "R10 pc_from_ir", pc_from_ir, s == 13 && ac_sign);
        nx = ref_next(s, w, opcode, r);
        @(negedge clk);
        check(state == nx, "R2 R3 R4 R5 R6 next state", state, nx);
    endtask

    function automatic logic rnd_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    initial begin
        opcode = 2'b00; ac_sign = 1'b0; mem_wait = 1'b0; rst = 1'b1;
        @(negedge clk);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        check(state == 4'd0, "R1 reset state", state, 0);

        // Path sweep: every opcode, both sign values, several wait streams (R11)
        for (int op = 0; op < 4; op++) begin
            for (int ac = 0; ac < 2; ac++) begin
                for (int rep = 0; rep < 6; rep++) begin
                    logic [3:0] path [16];
                    int n;
                    int len;
                    logic [3:0] exp_path [16];
                    opcode = op[1:0];
                    ac_sign = ac[0];
                    n = 1;
                    path[0] = state;
                    for (int k = 0; k < 400 && !(n > 1 && state == 0); k++) begin
                        logic [3:0] prev;
                        prev = state;
                        step(rnd_bit(), 1'b0);
                        if (state != prev && state != 0 && n < 16) begin
                            path[n] = state;
                            n++;
                        end
                        if (state == 0 && prev != 0) break;
                    end
                    for (int i = 0; i < 5; i++) exp_path[i] = i[3:0];
                    case (op)
                        0: begin exp_path[5] = 5; exp_path[6] = 6; exp_path[7] = 7; len = 8; end
                        1: begin exp_path[5] = 8; exp_path[6] = 9; len = 7; end
                        2: begin exp_path[5] = 10; exp_path[6] = 11; exp_path[7] = 12; len = 8; end
                        default: begin exp_path[5] = 13; len = 6; end
                    endcase
                    check(n == len, "R11 path length", n, len);
                    for (int i = 0; i < len && i < n; i++)
                        check(path[i] == exp_path[i], "R11 path order", path[i], exp_path[i]);
                end
            end
        end

        // Hold in state 1 with wait low, then reset arriving in state 4 (R5, R6, R1)
        opcode = 2'b10;
        check(state == 4'd0, "R5 start", state, 0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check(state == 4'd1, "R5 hold s1", state, 1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        check(state == 4'd4, "R6 reached s4", state, 4);
        step(1'b1, 1'b1);
        check(state == 4'd0, "R6 reset beats load", state, 0);
        step(1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule